// File: doc/BRIEF.md
# Disk Controller Host Data Register and FIFO

This block is the host-side data path of a disk controller. One read/write byte port carries command parameters toward the controller, sector data in either direction during a transfer, and result bytes back to the host. A controller-side byte strobe (`dev_stb_i`) stands in for the disk serializer and the command decoder. The current command phase comes from the decoder on `phase_i`: 0 = command, 1 = execution, 2 = result, and 3 is treated as command.

After reset the register passes one byte at a time. A configure write can turn on a 16-byte FIFO with a programmable service threshold. The FIFO is only used during the execution phase. In the command and result phases the port always holds a single byte under RQM/DIO handshaking. The FIFO is emptied each time a phase starts. A read overrun stops the transfer, but the host can still drain the bytes already queued. A write underrun fills the rest of the sector with zero bytes and then sends a CRC-16-CCITT, so the disk still gets a well-formed sector. The threshold sets how long the host may wait before service: with N bytes at rate R, the latency budget is about N·8/R minus 1.5 µs.

Controller states: `ST_CMD` (command bytes), `ST_XFER` (data transfer), `ST_PAD` (zero fill after underrun), `ST_CRCH` and `ST_CRCL` (CRC high and low byte), `ST_STOP` (transfer halted), `ST_RES` (result bytes). Transitions:
- A change of `phase_i` moves to `ST_CMD`, `ST_XFER` or `ST_RES`, and this takes priority over everything else.
- `ST_XFER` goes to `ST_PAD` on a write strobe with an empty queue.
- `ST_XFER` or `ST_PAD` goes to `ST_CRCH` when the last sector byte leaves.
- `ST_CRCH` goes to `ST_CRCL`, and `ST_CRCL` goes to `ST_STOP`, each on a strobe.
- `ST_XFER` goes to `ST_STOP` on a read strobe when the queue is full.

Top module: `fdc_data_fifo`

## Requirements
- R1: After reset the FIFO is disabled, the threshold code is 0, the state is `ST_CMD`, both error flags are 0, and the outputs are rqm=1, dio=0, drq=0.
- R2: A cycle with `cfg_we_i`=1 loads the FIFO enable and the threshold code. The threshold in bytes is the code plus one (1 to 16).
- R3: In the command phase the port holds one byte whether or not the FIFO is enabled. dio=0, and rqm=1 exactly when the holding byte is empty. A host write while rqm=0 is ignored. `dev_dout_o` shows the held byte (0x00 when empty), and a strobe consumes it.
- R4: Any change of `phase_i` empties the queue, clears the sector counter and presets the CRC, and the strobe of that cycle is ignored. `dir_write_i` is latched on entry (1 = host to disk).
- R5: In the execution phase the capacity is 16 with the FIFO enabled and 1 without it. dio=1 exactly when data flows toward the host. rqm=1 when the queue has room (host-to-disk) or holds a byte (disk-to-host).
- R6: With the FIFO enabled, drq=1 when free space ≥ threshold (host-to-disk, `ST_XFER` only) or when the filled count ≥ threshold (disk-to-host). With the FIFO disabled, drq follows rqm. drq is 0 outside the execution phase.
- R7: On a host-to-disk transfer each strobe sends the oldest queued byte on `dev_dout_o`. After the sector's last byte, two strobes send the CRC, high byte first. The CRC is polynomial 0x1021, preset 0xFFFF, MSB first, with no reflection and no final inversion, taken over all sector bytes including padding.
- R8: A host-to-disk strobe with an empty queue sends 0x00, sets `udr_o`, and pads the remaining sector bytes with 0x00. Host writes are refused from that cycle on, including one in the same cycle.
- R9: A disk-to-host strobe with the queue at capacity drops the byte, sets `ovr_o`, and moves to `ST_STOP`. Later strobes are ignored, but the host can still read the queued bytes.
- R10: `ovr_o` and `udr_o` stay set until the next entry into the command phase.
- R11: In the result phase the port holds one byte with dio=1. A strobe loads `dev_din_i` only when the port is empty, and a host read empties it.
- R12: After the CRC low byte the transfer is halted: rqm=0, `dev_dout_o`=0x00, and strobes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_i | input | 2 | Command phase: 0 command, 1 execution, 2 result, 3 command |
| dir_write_i | input | 1 | Transfer direction, latched on phase entry: 1 host to disk |
| cfg_we_i | input | 1 | Load FIFO enable and threshold |
| cfg_fifo_en_i | input | 1 | FIFO enable value |
| cfg_thr_i | input | 4 | Threshold code (bytes minus one) |
| host_wr_i | input | 1 | Host write strobe |
| host_wdata_i | input | 8 | Host write byte |
| host_rd_i | input | 1 | Host read strobe |
| host_rdata_o | output | 8 | Byte presented to the host |
| rqm_o | output | 1 | Port ready for the host |
| dio_o | output | 1 | 1 when data flows toward the host |
| drq_o | output | 1 | DMA service request |
| dev_stb_i | input | 1 | Controller-side byte strobe |
| dev_din_i | input | 8 | Byte from the disk or result source |
| dev_dout_o | output | 8 | Byte offered to the disk or decoder |
| ovr_o | output | 1 | Sticky overrun flag |
| udr_o | output | 1 | Sticky underrun flag |

## Verification
Two pairs of events can land in the same cycle. A host write can coincide with a strobe that finds the queue empty. Separately, a host write can coincide with a strobe that pops a queued byte. The bench raises `host_wr_i` and `dev_stb_i` together in both situations. In the underrun case it expects a 0x00 byte, `udr_o` set, and the written byte dropped, which it confirms through the all-zero padding and the CRC. In the pop case it expects the queue level unchanged and the next byte in order on `dev_dout_o`.

// File: rtl/fdc_fifo_pkg.sv
`timescale 1ns/1ps
package fdc_fifo_pkg;

    localparam logic [1:0] PH_CMD  = 2'd0;
    localparam logic [1:0] PH_EXEC = 2'd1;
    localparam logic [1:0] PH_RES  = 2'd2;

    typedef enum logic [2:0] {
        ST_CMD,
        ST_XFER,
        ST_PAD,
        ST_CRCH,
        ST_CRCL,
        ST_STOP,
        ST_RES
    } xfer_st_e;

    // One byte through CRC-16, polynomial 0x1021, MSB first
    function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        logic        fb;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            fb = r[15] ^ d[i];
            r  = {r[14:0], 1'b0};
            if (fb) r = r ^ 16'h1021;
        end
        return r;
    endfunction

endpackage

// File: rtl/fdc_byte_queue.sv
`timescale 1ns/1ps
module fdc_byte_queue #(
    parameter int  DEPTH = 16,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_i,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic [7:0]    din_i,
    output logic [7:0]    head_o,
    output logic [CW-1:0] count_o
);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr  <= '0;
            wr_ptr  <= '0;
            count_o <= '0;
        end else if (flush_i) begin
            rd_ptr  <= '0;
            wr_ptr  <= '0;
            count_o <= '0;
        end else begin
            if (push_i) wr_ptr <= bump(wr_ptr);
            if (pop_i)  rd_ptr <= bump(rd_ptr);
            unique case ({push_i, pop_i})
                2'b10:   count_o <= count_o + 1'b1;
                2'b01:   count_o <= count_o - 1'b1;
                default: count_o <= count_o;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push_i && !flush_i) mem[wr_ptr] <= din_i;
    end

    assign head_o = mem[rd_ptr];

endmodule

// File: rtl/fdc_crc16_reg.sv
`timescale 1ns/1ps
module fdc_crc16_reg
    import fdc_fifo_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init_i,
    input  logic        upd_i,
    input  logic [7:0]  din_i,
    output logic [15:0] crc_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      crc_o <= 16'hFFFF;
        else if (init_i) crc_o <= 16'hFFFF;
        else if (upd_i)  crc_o <= crc16_step(crc_o, din_i);
    end

endmodule

// File: rtl/fdc_xfer_fsm.sv
`timescale 1ns/1ps
module fdc_xfer_fsm
    import fdc_fifo_pkg::*;
#(
    parameter int  SECTOR_LEN = 8,
    localparam int SW         = $clog2(SECTOR_LEN + 1)
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic [1:0] phase_i,
    input  logic     dir_write_i,
    input  logic     dev_stb_i,
    input  logic     q_empty_i,
    input  logic     q_full_i,
    output xfer_st_e state_o,
    output logic     enter_o,
    output logic     wdir_o,
    output logic     underrun_o,
    output logic     overrun_o
);

    xfer_st_e      st, st_nx;
    logic [1:0]    phase_q;
    logic [SW-1:0] sent_q;
    logic          last_byte;
    logic          wr_stb;

    assign enter_o   = (phase_i != phase_q);
    assign last_byte = (sent_q == SW'(SECTOR_LEN - 1));
    assign wr_stb    = dev_stb_i && wdir_o && !enter_o;

    // state register, phase tracking, sector counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= ST_CMD;
            phase_q <= PH_CMD;
            wdir_o  <= 1'b0;
            sent_q  <= '0;
        end else begin
            st      <= st_nx;
            phase_q <= phase_i;
            if (enter_o) begin
                wdir_o <= dir_write_i;
                sent_q <= '0;
            end else if (wr_stb && (st == ST_XFER || st == ST_PAD)) begin
                sent_q <= sent_q + 1'b1;
            end
        end
    end

    // next state
    always_comb begin
        st_nx = st;
        if (enter_o) begin
            unique case (phase_i)
                PH_EXEC: st_nx = ST_XFER;
                PH_RES:  st_nx = ST_RES;
                default: st_nx = ST_CMD;
            endcase
        end else begin
            unique case (st)
                ST_XFER: begin
                    if (wr_stb) begin
                        if (last_byte)      st_nx = ST_CRCH;
                        else if (q_empty_i) st_nx = ST_PAD;
                    end else if (dev_stb_i && !wdir_o && q_full_i) begin
                        st_nx = ST_STOP;
                    end
                end
                ST_PAD:  if (wr_stb && last_byte) st_nx = ST_CRCH;
                ST_CRCH: if (wr_stb) st_nx = ST_CRCL;
                ST_CRCL: if (wr_stb) st_nx = ST_STOP;
                default: st_nx = st;
            endcase
        end
    end

    // outputs
    always_comb begin
        state_o    = st;
        underrun_o = (st == ST_XFER) && wr_stb && q_empty_i;
        overrun_o  = (st == ST_XFER) && dev_stb_i && !wdir_o && !enter_o && q_full_i;
    end

endmodule

// File: rtl/fdc_data_fifo.sv
`timescale 1ns/1ps
module fdc_data_fifo
    import fdc_fifo_pkg::*;
#(
    parameter int  DEPTH      = 16,
    parameter int  SECTOR_LEN = 8,
    localparam int THR_W      = $clog2(DEPTH),
    localparam int CW         = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       phase_i,
    input  logic             dir_write_i,
    input  logic             cfg_we_i,
    input  logic             cfg_fifo_en_i,
    input  logic [THR_W-1:0] cfg_thr_i,
    input  logic             host_wr_i,
    input  logic [7:0]       host_wdata_i,
    input  logic             host_rd_i,
    output logic [7:0]       host_rdata_o,
    output logic             rqm_o,
    output logic             dio_o,
    output logic             drq_o,
    input  logic             dev_stb_i,
    input  logic [7:0]       dev_din_i,
    output logic [7:0]       dev_dout_o,
    output logic             ovr_o,
    output logic             udr_o
);

    xfer_st_e         st;
    logic             enter, wdir, underrun, overrun;
    logic             fifo_en_q;
    logic [THR_W-1:0] thr_code_q;
    logic [CW-1:0]    q_count, cap, thr, free_cnt;
    logic [7:0]       q_head, q_din;
    logic             q_push, q_pop, q_empty, q_full;
    logic             in_exec, can_wr, can_rd;
    logic             hw_acc, hr_acc, dev_pop, dev_push;
    logic [15:0]      crc;
    logic             crc_upd;

    fdc_xfer_fsm #(.SECTOR_LEN(SECTOR_LEN)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_i    (phase_i),
        .dir_write_i(dir_write_i),
        .dev_stb_i  (dev_stb_i),
        .q_empty_i  (q_empty),
        .q_full_i   (q_full),
        .state_o    (st),
        .enter_o    (enter),
        .wdir_o     (wdir),
        .underrun_o (underrun),
        .overrun_o  (overrun)
    );

    fdc_byte_queue #(.DEPTH(DEPTH)) u_queue (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush_i(enter),
        .push_i (q_push),
        .pop_i  (q_pop),
        .din_i  (q_din),
        .head_o (q_head),
        .count_o(q_count)
    );

    fdc_crc16_reg u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .init_i(enter),
        .upd_i (crc_upd),
        .din_i (dev_dout_o),
        .crc_o (crc)
    );

    // configuration and sticky flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fifo_en_q  <= 1'b0;
            thr_code_q <= '0;
            ovr_o      <= 1'b0;
            udr_o      <= 1'b0;
        end else begin
            if (cfg_we_i) begin
                fifo_en_q  <= cfg_fifo_en_i;
                thr_code_q <= cfg_thr_i;
            end
            if (enter && !(phase_i == PH_EXEC || phase_i == PH_RES)) begin
                ovr_o <= 1'b0;
                udr_o <= 1'b0;
            end else begin
                if (overrun)  ovr_o <= 1'b1;
                if (underrun) udr_o <= 1'b1;
            end
        end
    end

    // capacity, handshake and service request
    always_comb begin
        in_exec  = (st == ST_XFER) || (st == ST_PAD) || (st == ST_CRCH) ||
                   (st == ST_CRCL) || (st == ST_STOP);
        cap      = (fifo_en_q && in_exec) ? CW'(DEPTH) : CW'(1);
        q_empty  = (q_count == '0);
        q_full   = (q_count >= cap);
        thr      = CW'(thr_code_q) + 1'b1;
        free_cnt = CW'(DEPTH) - q_count;
        dio_o    = (st == ST_RES) || (in_exec && !wdir);
        can_wr   = ((st == ST_CMD) || (st == ST_XFER && wdir)) && !q_full;
        can_rd   = dio_o && !q_empty;
        rqm_o    = dio_o ? can_rd : can_wr;
        if (!in_exec)       drq_o = 1'b0;
        else if (!fifo_en_q) drq_o = rqm_o;
        else if (wdir)      drq_o = (st == ST_XFER) && (free_cnt >= thr);
        else                drq_o = (q_count >= thr);
    end

    // byte movement
    always_comb begin
        hw_acc   = host_wr_i && can_wr && !enter && !underrun;
        hr_acc   = host_rd_i && can_rd && !enter;
        dev_pop  = dev_stb_i && !enter && !q_empty &&
                   ((st == ST_CMD) || (st == ST_XFER && wdir));
        dev_push = dev_stb_i && !enter &&
                   ((st == ST_RES && q_empty) || (st == ST_XFER && !wdir && !q_full));
        q_push   = hw_acc || dev_push;
        q_pop    = hr_acc || dev_pop;
        q_din    = hw_acc ? host_wdata_i : dev_din_i;
        crc_upd  = dev_stb_i && !enter && wdir && ((st == ST_XFER) || (st == ST_PAD));
        host_rdata_o = q_head;
    end

    always_comb begin
        unique case (st)
            ST_CMD, ST_XFER: dev_dout_o = q_empty ? 8'h00 : q_head;
            ST_CRCH:         dev_dout_o = crc[15:8];
            ST_CRCL:         dev_dout_o = crc[7:0];
            default:         dev_dout_o = 8'h00;
        endcase
    end

endmodule

// File: rtl/fdc_data_fifo_chk.sv
`timescale 1ns/1ps
module fdc_data_fifo_chk
    import fdc_fifo_pkg::*;
#(
    parameter int CW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input xfer_st_e      st,
    input logic          enter,
    input logic          wdir,
    input logic [CW-1:0] count,
    input logic [1:0]    phase_i,
    input logic          host_wr_i,
    input logic          host_rd_i,
    input logic          dev_stb_i,
    input logic [7:0]    dev_dout_o,
    input logic          rqm_o,
    input logic          drq_o,
    input logic          ovr_o,
    input logic          udr_o
);

    logic to_cmd;
    assign to_cmd = enter && !(phase_i == PH_EXEC || phase_i == PH_RES);

    // R3
    cmd_single_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CMD && !enter && host_wr_i && rqm_o) |=> !rqm_o);

    // R10
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_o && !to_cmd) |=> ovr_o);

    // R10
    udr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (udr_o && !to_cmd) |=> udr_o);

    // R8
    udr_zero_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(udr_o) |-> ($past(dev_dout_o) == 8'h00));

    // R12
    halted_no_rqm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STOP && wdir) |-> !rqm_o);

    // R6
    drq_exec_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drq_o |-> (st != ST_CMD && st != ST_RES));

    // R9
    ovr_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STOP && !wdir && dev_stb_i && !host_rd_i && !enter) |=> $stable(count));

endmodule

bind fdc_data_fifo fdc_data_fifo_chk #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (st),
    .enter     (enter),
    .wdir      (wdir),
    .count     (q_count),
    .phase_i   (phase_i),
    .host_wr_i (host_wr_i),
    .host_rd_i (host_rd_i),
    .dev_stb_i (dev_stb_i),
    .dev_dout_o(dev_dout_o),
    .rqm_o     (rqm_o),
    .drq_o     (drq_o),
    .ovr_o     (ovr_o),
    .udr_o     (udr_o)
);

// File: tb/sim_fdc_data_fifo.sv
`timescale 1ns/1ps
module sim_fdc_data_fifo;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] phase = 2'd0;
    logic       dirw = 1'b0;
    logic       cfg_we = 1'b0, cfg_en = 1'b0;
    logic [3:0] cfg_thr = 4'd0;
    logic       hwr = 1'b0, hrd = 1'b0, stb = 1'b0;
    logic [7:0] hwd = 8'h00, ddin = 8'h00;
    logic [7:0] hrdata, ddout;
    logic       rqm, dio, drq, ovr, udr;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fdc_data_fifo u0 (
        .clk(clk), .rst_n(rst_n), .phase_i(phase), .dir_write_i(dirw),
        .cfg_we_i(cfg_we), .cfg_fifo_en_i(cfg_en), .cfg_thr_i(cfg_thr),
        .host_wr_i(hwr), .host_wdata_i(hwd), .host_rd_i(hrd), .host_rdata_o(hrdata),
        .rqm_o(rqm), .dio_o(dio), .drq_o(drq),
        .dev_stb_i(stb), .dev_din_i(ddin), .dev_dout_o(ddout),
        .ovr_o(ovr), .udr_o(udr)
    );

    // vector: {host_wr, strobe, wdata, exp_drq, exp_rqm, exp_dout}
    localparam logic [19:0] VEC [20] = '{
        {1'b1,1'b0,8'hA0,1'b1,1'b1,8'hA0}, {1'b1,1'b0,8'hA1,1'b1,1'b1,8'hA0},
        {1'b1,1'b0,8'hA2,1'b1,1'b1,8'hA0}, {1'b1,1'b0,8'hA3,1'b1,1'b1,8'hA0},
        {1'b1,1'b0,8'hA4,1'b1,1'b1,8'hA0}, {1'b1,1'b0,8'hA5,1'b1,1'b1,8'hA0},
        {1'b1,1'b0,8'hA6,1'b1,1'b1,8'hA0}, {1'b1,1'b0,8'hA7,1'b1,1'b1,8'hA0},
        {1'b1,1'b0,8'hA8,1'b1,1'b1,8'hA0}, {1'b1,1'b0,8'hA9,1'b1,1'b1,8'hA0},
        {1'b1,1'b0,8'hAA,1'b1,1'b1,8'hA0}, {1'b1,1'b0,8'hAB,1'b1,1'b1,8'hA0},
        {1'b1,1'b0,8'hAC,1'b0,1'b1,8'hA0}, {1'b0,1'b1,8'h00,1'b1,1'b1,8'hA1},
        {1'b1,1'b1,8'hAD,1'b1,1'b1,8'hA2}, {1'b0,1'b1,8'h00,1'b1,1'b1,8'hA3},
        {1'b0,1'b1,8'h00,1'b1,1'b1,8'hA4}, {1'b0,1'b1,8'h00,1'b1,1'b1,8'hA5},
        {1'b0,1'b1,8'h00,1'b1,1'b1,8'hA6}, {1'b0,1'b1,8'h00,1'b1,1'b1,8'hA7}
    };

    function automatic logic [15:0] ref_crc(input logic [7:0] b [8]);
        logic [15:0] c = 16'hFFFF;
        for (int k = 0; k < 8; k++) begin
            c = c ^ {b[k], 8'h00};
            for (int j = 0; j < 8; j++)
                c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
        end
        return c;
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic go_phase(input logic [1:0] p, input logic w);
        phase = p; dirw = w; tick();
    endtask

    task automatic hwrite(input logic [7:0] d);
        hwr = 1'b1; hwd = d; tick(); hwr = 1'b0;
    endtask

    task automatic strobe(input logic [7:0] d);
        stb = 1'b1; ddin = d; tick(); stb = 1'b0;
    endtask

    task automatic hread(output logic [7:0] d);
        d = hrdata; hrd = 1'b1; tick(); hrd = 1'b0;
    endtask

    task automatic config_fifo(input logic en, input logic [3:0] code);
        cfg_we = 1'b1; cfg_en = en; cfg_thr = code; tick(); cfg_we = 1'b0;
    endtask

    task automatic do_reset();
        phase = 2'd0; rst_n = 1'b0; tick(); tick(); rst_n = 1'b1; tick();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] rd;
        logic [7:0] sec [8];
        logic [15:0] c;

        do_reset();
        chk("R1 rqm", {15'd0, rqm}, 16'd1);
        chk("R1 dio", {15'd0, dio}, 16'd0);
        chk("R1 drq", {15'd0, drq}, 16'd0);
        chk("R1 flags", {14'd0, ovr, udr}, 16'd0);

        // R3: single byte in command phase even with FIFO on
        config_fifo(1'b1, 4'd3);
        hwrite(8'h55);
        chk("R3 rqm full", {15'd0, rqm}, 16'd0);
        chk("R3 dout", {8'd0, ddout}, 16'h0055);
        hwrite(8'h66);
        chk("R3 write ignored", {8'd0, ddout}, 16'h0055);
        strobe(8'h00);
        chk("R3 consumed rqm", {15'd0, rqm}, 16'd1);
        chk("R3 consumed dout", {8'd0, ddout}, 16'h0000);

        // R4: leftover command byte flushed on execution entry
        hwrite(8'h77);
        go_phase(2'd1, 1'b0);
        chk("R4 flush rqm", {15'd0, rqm}, 16'd0);
        chk("R5 dio read", {15'd0, dio}, 16'd1);

        // R2/R6: read threshold 2
        config_fifo(1'b1, 4'd1);
        strobe(8'h31);
        chk("R6 below thr drq", {15'd0, drq}, 16'd0);
        chk("R5 read rqm", {15'd0, rqm}, 16'd1);
        strobe(8'h32);
        chk("R2 R6 at thr drq", {15'd0, drq}, 16'd1);
        hread(rd);
        chk("R5 read data", {8'd0, rd}, 16'h0031);
        hread(rd);
        chk("R5 read order", {8'd0, rd}, 16'h0032);
        chk("R5 drained rqm", {15'd0, rqm}, 16'd0);

        // R7 table walk: FIFO write, threshold 4, sector of 8
        config_fifo(1'b1, 4'd3);
        go_phase(2'd0, 1'b0);
        go_phase(2'd1, 1'b1);
        chk("R6 write empty drq", {15'd0, drq}, 16'd1);
        chk("R5 dio write", {15'd0, dio}, 16'd0);
        for (int i = 0; i < 20; i++) begin
            hwr = VEC[i][19]; stb = VEC[i][18]; hwd = VEC[i][17:10];
            tick();
            hwr = 1'b0; stb = 1'b0;
            chk($sformatf("R6 vec%0d drq", i), {15'd0, drq}, {15'd0, VEC[i][9]});
            chk($sformatf("R5 vec%0d rqm", i), {15'd0, rqm}, {15'd0, VEC[i][8]});
            chk($sformatf("R7 vec%0d dout", i), {8'd0, ddout}, {8'd0, VEC[i][7:0]});
        end
        for (int k = 0; k < 8; k++) sec[k] = 8'hA0 + 8'(k);
        c = ref_crc(sec);
        strobe(8'h00);
        chk("R7 crc high", {8'd0, ddout}, {8'd0, c[15:8]});
        chk("R7 crc rqm", {15'd0, rqm}, 16'd0);
        strobe(8'h00);
        chk("R7 crc low", {8'd0, ddout}, {8'd0, c[7:0]});
        strobe(8'h00);
        chk("R12 halted dout", {8'd0, ddout}, 16'h0000);
        chk("R12 halted rqm", {15'd0, rqm}, 16'd0);
        strobe(8'h00);
        chk("R12 strobe ignored", {8'd0, ddout}, 16'h0000);

        // R8: underrun with a same-cycle host write, padding and CRC
        go_phase(2'd0, 1'b0);
        go_phase(2'd1, 1'b1);
        hwrite(8'hB0); hwrite(8'hB1); hwrite(8'hB2);
        strobe(8'h00); strobe(8'h00);
        chk("R7 head order", {8'd0, ddout}, 16'h00B2);
        strobe(8'h00);
        chk("R8 empty dout", {8'd0, ddout}, 16'h0000);
        hwr = 1'b1; hwd = 8'hC0; stb = 1'b1;
        tick();
        hwr = 1'b0; stb = 1'b0;
        chk("R8 udr set", {15'd0, udr}, 16'd1);
        chk("R8 rqm off", {15'd0, rqm}, 16'd0);
        for (int k = 0; k < 4; k++) begin
            chk("R8 pad byte", {8'd0, ddout}, 16'h0000);
            hwrite(8'hC1);
            strobe(8'h00);
        end
        sec[0] = 8'hB0; sec[1] = 8'hB1; sec[2] = 8'hB2;
        for (int k = 3; k < 8; k++) sec[k] = 8'h00;
        c = ref_crc(sec);
        chk("R8 R7 padded crc high", {8'd0, ddout}, {8'd0, c[15:8]});
        strobe(8'h00);
        chk("R8 R7 padded crc low", {8'd0, ddout}, {8'd0, c[7:0]});

        // R10/R11: result phase, flag kept until command entry
        go_phase(2'd2, 1'b0);
        chk("R10 udr kept", {15'd0, udr}, 16'd1);
        chk("R11 dio", {15'd0, dio}, 16'd1);
        chk("R11 empty rqm", {15'd0, rqm}, 16'd0);
        strobe(8'hE5);
        chk("R11 loaded rqm", {15'd0, rqm}, 16'd1);
        strobe(8'hE6);
        hread(rd);
        chk("R11 result byte", {8'd0, rd}, 16'h00E5);
        chk("R11 emptied", {15'd0, rqm}, 16'd0);
        go_phase(2'd0, 1'b0);
        chk("R10 udr cleared", {15'd0, udr}, 16'd0);

        // R1/R9: reset disables FIFO; byte-mode overrun
        do_reset();
        go_phase(2'd1, 1'b0);
        strobe(8'h41);
        chk("R6 byte mode drq", {15'd0, drq}, 16'd1);
        strobe(8'h42);
        chk("R9 ovr set", {15'd0, ovr}, 16'd1);
        hread(rd);
        chk("R9 drain keeps byte", {8'd0, rd}, 16'h0041);
        chk("R9 drained", {15'd0, rqm}, 16'd0);
        strobe(8'h43);
        chk("R9 strobe ignored", {15'd0, rqm}, 16'd0);
        go_phase(2'd0, 1'b0);
        chk("R10 ovr cleared", {15'd0, ovr}, 16'd0);
        go_phase(2'd1, 1'b1);
        hwrite(8'h01);
        chk("R1 R5 fifo off cap one", {15'd0, rqm}, 16'd0);

        finish_run();
    end

endmodule